// File: doc/BRIEF.md
# ADC conversion control register with suspend sequencing

This block sits in front of a simple analog conversion engine and owns its single 16-bit control word. Software writes the word over a plain write strobe and data bus and reads it back on a read-data port. The word holds a self-clearing soft-reset bit, a two-bit suspend-mode field, a four-bit acquisition-window field and a clock-prescale bit. From the prescale bit the block makes the converter clock. It is a clock-enable strobe that fires on every input clock, or on every second one. All sequencing logic advances only on that strobe.

A start request launches a sequence of one to sixteen conversions. Each conversion opens with a start-of-conversion pulse whose width comes from the acquisition field. The block then waits for the converter's conversion-done signal. A debug-suspend input can halt a running sequence, and the selected mode sets the stopping point: never, at the end of the sequence, at the end of the current conversion, or at once. When suspend is released, the halted sequence carries on from where it stopped.

Top module: `cnv_ctl_top`

## Requirements
- R1: Read-data bits 15, 14 and 6:0 always read 0, whatever was written to them.
- R2: All fields are 0 after reset. Bits 13:12 (suspend mode), 11:8 (acquisition) and 7 (prescale) hold the last accepted write and read back at those positions.
- R3: Writing 1 to bit 14 clears every field and aborts any sequence in the next cycle, so busy, halted and soc read 0. Writes in the two following ADC-clock cycles are dropped. A write in the third cycle is accepted.
- R4: With bit 7 = 0, adc_tick is high on every clock. With bit 7 = 1, adc_tick is high on every second clock.
- R5: Each soc pulse lasts (acquisition + 1) ADC-clock ticks. conv_done is sampled only on ticks, and only after soc has ended.
- R6: seq_len holds the number of conversions minus one. A sequence produces exactly seq_len + 1 soc pulses. busy rises with the first soc and falls after the last accepted conv_done.
- R7: start is ignored while busy is high or while halted is high.
- R8: Suspend mode 00 never halts, even with susp held high.
- R9: Mode 01 lets the sequence run to its last conversion-done and then halts with busy low. Release returns to idle.
- R10: Mode 10 halts after the current conversion's done, with busy still high. Release starts the next conversion, and the total pulse count is unchanged.
- R11: Mode 11 halts on the next tick, and soc drops. A conv_done during the halt is ignored. Release restarts the interrupted conversion with a full-width soc pulse.
- R12: With susp high and a mode other than 00, an idle block goes to halted on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control-word write strobe |
| reg_wdata | input | 16 | Control-word write data |
| reg_rdata | output | 16 | Control-word read data |
| seq_len | input | SEQ_W | Conversions per sequence minus one |
| start | input | 1 | Sequence start request |
| conv_done | input | 1 | Converter reports a finished conversion |
| susp | input | 1 | Debug suspend request |
| adc_tick | output | 1 | ADC-clock enable strobe |
| soc | output | 1 | Start-of-conversion pulse |
| busy | output | 1 | A sequence is in progress |
| halted | output | 1 | Sequencer is stopped by suspend |

## Verification
The bench sweeps every acquisition value against several sequence lengths at both prescale settings. It measures soc width and pulse count, so an off-by-one window or a lost conversion shows up as a count error. The soft-reset window is tested with writes in the first, second and third cycles afterwards, which catches a latency that is too short or too long. Each suspend mode is driven at its own boundary. A mode 11 design that resumed mid-pulse would give a short soc. A mode 10 design that skipped the remaining count would give fewer pulses. An idle block that ignored suspend would accept the start it should refuse.

// File: rtl/cnv_ctl_pkg.sv
`timescale 1ns/1ps
package cnv_ctl_pkg;
   localparam int REG_W    = 16;
   localparam int BIT_SRST = 14;
   localparam int MODE_LSB = 12;
   localparam int ACQ_LSB  = 8;
   localparam int ACQ_W    = 4;
   localparam int BIT_PRE  = 7;
   localparam logic [REG_W-1:0] RW_MASK = 16'h3F80;

   typedef enum logic [1:0] {
      SUSP_OFF = 2'b00,
      SUSP_SEQ = 2'b01,
      SUSP_CNV = 2'b10,
      SUSP_NOW = 2'b11
   } susp_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SOC,
      ST_WAIT,
      ST_HALT
   } seq_st_e;

   typedef struct packed {
      susp_mode_e       mode;
      logic [ACQ_W-1:0] acq;
      logic             pre;
   } cfg_t;
endpackage

// File: rtl/cnv_ctl_regs.sv
`timescale 1ns/1ps
module cnv_ctl_regs
   import cnv_ctl_pkg::*;
#(
   parameter int SRST_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output cfg_t             cfg,
   output logic             srst_hold,
   output logic             seq_clr
);
   localparam int CW = $clog2(SRST_CYC + 1);

   if (SRST_CYC < 1) begin : g_bad_srst
      $error("SRST_CYC must be at least 1");
   end

   logic [CW-1:0] hold_cnt;
   logic          srst_hit;
   logic          unused_bits;

   assign srst_hit    = wr_en && (hold_cnt == '0) && wdata[BIT_SRST];
   assign srst_hold   = (hold_cnt != '0);
   assign seq_clr     = srst_hit || srst_hold;
   assign unused_bits = ^{wdata[REG_W-1], wdata[BIT_PRE-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         cfg      <= '0;
      end else if (srst_hit) begin
         hold_cnt <= CW'(SRST_CYC);
         cfg      <= '0;
      end else begin
         if (srst_hold && tick)
            hold_cnt <= hold_cnt - 1'b1;
         if (!srst_hold && wr_en) begin
            cfg.mode <= susp_mode_e'(wdata[MODE_LSB +: 2]);
            cfg.acq  <= wdata[ACQ_LSB +: ACQ_W];
            cfg.pre  <= wdata[BIT_PRE];
         end
      end
   end

   always_comb begin
      rdata                     = '0;
      rdata[MODE_LSB +: 2]      = cfg.mode;
      rdata[ACQ_LSB +: ACQ_W]   = cfg.acq;
      rdata[BIT_PRE]            = cfg.pre;
   end
endmodule

// File: rtl/cnv_ctl_clkdiv.sv
`timescale 1ns/1ps
module cnv_ctl_clkdiv #(
   parameter int DIV_SLOW = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pre,
   output logic tick
);
   if (DIV_SLOW < 2) begin : g_bad_div
      $error("DIV_SLOW must be at least 2");
   end

   if (DIV_SLOW == 2) begin : g_tog
      logic ph;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ph <= 1'b0;
         else if (clr || !pre)
            ph <= 1'b0;
         else
            ph <= ~ph;
      end
      assign tick = !pre || ph;
   end else begin : g_cnt
      localparam int DW = $clog2(DIV_SLOW);
      localparam logic [DW-1:0] LAST = DW'(DIV_SLOW - 1);
      logic [DW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (clr || !pre || cnt == LAST)
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
      assign tick = !pre || (cnt == LAST);
   end
endmodule

// File: rtl/cnv_ctl_seq.sv
`timescale 1ns/1ps
module cnv_ctl_seq
   import cnv_ctl_pkg::*;
#(
   parameter int SEQ_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  susp_mode_e       mode,
   input  logic [ACQ_W-1:0] acq,
   input  logic [SEQ_W-1:0] seq_len,
   input  logic             start,
   input  logic             conv_done,
   input  logic             susp,
   output logic             soc,
   output logic             busy,
   output logic             halted
);
   seq_st_e          st;
   seq_st_e          resume;
   logic [ACQ_W-1:0] win;
   logic [SEQ_W-1:0] left;
   logic             hold;
   logic             last;

   assign hold = susp && (mode != SUSP_OFF);
   assign last = (left == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         st     <= ST_IDLE;
         resume <= ST_IDLE;
         win    <= '0;
         left   <= '0;
      end else if (tick) begin
         unique case (st)
            ST_IDLE: begin
               if (hold) begin
                  st     <= ST_HALT;
                  resume <= ST_IDLE;
               end else if (start) begin
                  st   <= ST_SOC;
                  win  <= '0;
                  left <= seq_len;
               end
            end
            ST_SOC: begin
               if (hold && mode == SUSP_NOW) begin
                  st     <= ST_HALT;
                  resume <= ST_SOC;
               end else if (win == acq) begin
                  st <= ST_WAIT;
               end else begin
                  win <= win + 1'b1;
               end
            end
            ST_WAIT: begin
               if (hold && mode == SUSP_NOW) begin
                  st     <= ST_HALT;
                  resume <= ST_SOC;
               end else if (conv_done) begin
                  win <= '0;
                  if (last) begin
                     if (hold) begin
                        st     <= ST_HALT;
                        resume <= ST_IDLE;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     left <= left - 1'b1;
                     if (hold && mode == SUSP_CNV) begin
                        st     <= ST_HALT;
                        resume <= ST_SOC;
                     end else begin
                        st <= ST_SOC;
                     end
                  end
               end
            end
            ST_HALT: begin
               if (!hold) begin
                  st  <= resume;
                  win <= '0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign soc    = (st == ST_SOC);
   assign halted = (st == ST_HALT);
   assign busy   = (st == ST_SOC) || (st == ST_WAIT) ||
                   ((st == ST_HALT) && (resume != ST_IDLE));
endmodule

// File: rtl/cnv_ctl_top.sv
`timescale 1ns/1ps
module cnv_ctl_top
   import cnv_ctl_pkg::*;
#(
   parameter int SEQ_W    = 4,
   parameter int SRST_CYC = 2,
   parameter int DIV_SLOW = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   input  logic [SEQ_W-1:0] seq_len,
   input  logic             start,
   input  logic             conv_done,
   input  logic             susp,
   output logic             adc_tick,
   output logic             soc,
   output logic             busy,
   output logic             halted
);
   if (SEQ_W < 1 || SEQ_W > 8) begin : g_bad_seqw
      $error("SEQ_W must lie in 1..8");
   end

   cfg_t cfg;
   logic srst_hold;
   logic seq_clr;

   cnv_ctl_regs #(.SRST_CYC(SRST_CYC)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (adc_tick),
      .wr_en     (reg_wr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .cfg       (cfg),
      .srst_hold (srst_hold),
      .seq_clr   (seq_clr)
   );

   cnv_ctl_clkdiv #(.DIV_SLOW(DIV_SLOW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (seq_clr),
      .pre   (cfg.pre),
      .tick  (adc_tick)
   );

   cnv_ctl_seq #(.SEQ_W(SEQ_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (seq_clr),
      .tick      (adc_tick),
      .mode      (cfg.mode),
      .acq       (cfg.acq),
      .seq_len   (seq_len),
      .start     (start),
      .conv_done (conv_done),
      .susp      (susp),
      .soc       (soc),
      .busy      (busy),
      .halted    (halted)
   );
endmodule

// File: rtl/cnv_ctl_chk.sv
`timescale 1ns/1ps
module cnv_ctl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic [15:0] reg_wdata,
   input logic [15:0] reg_rdata,
   input logic        adc_tick,
   input logic        soc,
   input logic        busy,
   input logic        halted,
   input logic        susp,
   input logic        conv_done,
   input logic        seq_clr,
   input logic        srst_hold
);
   assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[15:14] == 2'b00 && reg_rdata[6:0] == 7'd0);

   assert_srst_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[14] && !srst_hold) |=> (reg_rdata == 16'd0 && !busy && !halted && !soc));

   assert_srst_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      srst_hold |=> $stable(reg_rdata));

   assert_tick_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[7] |-> adc_tick);

   assert_tick_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[7] && adc_tick) |=> (!adc_tick || !reg_rdata[7]));

   assert_soc_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soc |-> busy);

   assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(seq_clr)) |-> $past(conv_done));

   assert_halt_nostart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !busy) |=> !soc);

   assert_off_nohalt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[13:12] == 2'b00 && !halted) |=> !halted);

   assert_now_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[13:12] == 2'b11 && susp && soc && adc_tick && !seq_clr) |=> (halted && !soc));

   assert_halt_nosoc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !soc);
endmodule

bind cnv_ctl_top cnv_ctl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .adc_tick  (adc_tick),
   .soc       (soc),
   .busy      (busy),
   .halted    (halted),
   .susp      (susp),
   .conv_done (conv_done),
   .seq_clr   (seq_clr),
   .srst_hold (srst_hold)
);

// File: tb/tb_cnv_ctl_top.sv
`timescale 1ns/1ps
module tb_cnv_ctl_top;
   localparam int SEQ_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [15:0]      reg_wdata = '0;
   logic [15:0]      reg_rdata;
   logic [SEQ_W-1:0] seq_len = '0;
   logic             start = 1'b0;
   logic             conv_done;
   logic             susp = 1'b0;
   logic             adc_tick, soc, busy, halted;

   logic resp_done = 1'b0;
   logic man_done  = 1'b0;
   logic auto_done = 1'b0;
   assign conv_done = resp_done | man_done;

   int n_chk = 0;
   int n_fail = 0;
   int soc_hi = 0, rises = 0, halt_seen = 0, ticks = 0;
   int lat = 0, done_len = 0;
   logic soc_q = 1'b0;

   always #2.5 clk = ~clk;

   cnv_ctl_top #(.SEQ_W(SEQ_W)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .seq_len(seq_len), .start(start),
      .conv_done(conv_done), .susp(susp), .adc_tick(adc_tick),
      .soc(soc), .busy(busy), .halted(halted)
   );

   // converter model: done arrives a few clocks after soc ends, held two clocks
   always @(negedge clk) begin
      resp_done = 1'b0;
      if (done_len != 0) begin
         resp_done = 1'b1;
         done_len  = done_len - 1;
      end else if (lat != 0) begin
         lat = lat - 1;
         if (lat == 0) begin
            resp_done = 1'b1;
            done_len  = 1;
         end
      end
      if (auto_done && soc_q && !soc) lat = 3;
      if (soc) soc_hi++;
      if (soc && !soc_q) rises++;
      if (halted) halt_seen++;
      if (adc_tick) ticks++;
      soc_q = soc;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic reg_write(input logic [15:0] v);
      reg_wr    = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic wait_busy(input bit lvl, input int lim, input string req);
      int n = 0;
      while (busy !== lvl && n < lim) begin
         @(negedge clk);
         n++;
      end
      chk(busy === lvl, req, int'(busy), int'(lvl));
   endtask

   task automatic run_seq(input bit pre, input int acq, input int len);
      int r0, h0, exp_hi;
      reg_write(16'(acq << 8) | (pre ? 16'h0080 : 16'h0000));
      seq_len   = SEQ_W'(len);
      auto_done = 1'b1;
      r0 = rises;
      h0 = soc_hi;
      start = 1'b1;
      wait_busy(1'b1, 10, "R6 busy rise");
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; // request while busy: R7 says ignore
      @(negedge clk);
      start = 1'b0;
      wait_busy(1'b0, 3000, "R6 busy fall");
      cyc(2);
      exp_hi = (len + 1) * (acq + 1) * (pre ? 2 : 1);
      chk(rises - r0 == len + 1, "R6/R7 soc count", rises - r0, len + 1);
      chk(soc_hi - h0 == exp_hi, "R5 soc width", soc_hi - h0, exp_hi);
      auto_done = 1'b0;
   endtask

   initial begin
      int t0, r0, h0;
      logic [15:0] v;
      cyc(4);
      chk(reg_rdata == 16'h0000, "R2 reset value", reg_rdata, 0);
      chk(!busy && !soc && !halted, "R2 reset outputs", {busy, soc, halted}, 0);
      rst_n = 1'b1;
      cyc(1);

      // R1/R2: every single-bit write except the soft-reset bit
      for (int b = 0; b < 16; b++) begin
         if (b != 14) begin
            v = 16'(1 << b);
            reg_write(v);
            chk(reg_rdata == (v & 16'h3F80), "R1/R2 bit write", reg_rdata, v & 16'h3F80);
         end
      end
      reg_write(16'hBFFF);
      chk(reg_rdata == 16'h3F80, "R1 all bits", reg_rdata, 16'h3F80);

      // R4: tick rate
      reg_write(16'h0000);
      t0 = ticks; cyc(20);
      chk(ticks - t0 == 20, "R4 undivided", ticks - t0, 20);
      reg_write(16'h0080);
      t0 = ticks; cyc(20);
      chk(ticks - t0 == 10, "R4 divided", ticks - t0, 10);

      // R5/R6/R7 sweep
      for (int p = 0; p < 2; p++)
         for (int a = 0; a < 16; a++) begin
            run_seq(p[0], a, 0);
            run_seq(p[0], a, 1);
            run_seq(p[0], a, 5);
         end
      run_seq(1'b0, 0, 15);

      // R3: soft reset aborts a running sequence, then the write window
      reg_write(16'h0580);
      seq_len = 4'd3;
      start = 1'b1;
      wait_busy(1'b1, 10, "R3 setup");
      start = 1'b0;
      cyc(1);
      reg_write(16'h4A00);
      chk(reg_rdata == 16'h0000, "R3 fields cleared", reg_rdata, 0);
      chk(!busy && !soc && !halted, "R3 sequence aborted", {busy, soc, halted}, 0);
      reg_write(16'h0500);
      chk(reg_rdata == 16'h0000, "R3 first window write dropped", reg_rdata, 0);
      reg_write(16'h0500);
      chk(reg_rdata == 16'h0000, "R3 second window write dropped", reg_rdata, 0);
      reg_write(16'h0600);
      chk(reg_rdata == 16'h0600, "R3 third write taken", reg_rdata, 16'h0600);

      // R8: mode 00 ignores suspend
      reg_write(16'h0200);
      seq_len = 4'd2;
      susp = 1'b1;
      h0 = halt_seen;
      run_seq(1'b0, 2, 2);
      chk(halt_seen - h0 == 0, "R8 never halted", halt_seen - h0, 0);
      susp = 1'b0;

      // R12 and R9
      reg_write(16'h1100);
      susp = 1'b1;
      cyc(1);
      chk(halted == 1'b1, "R12 idle halt", halted, 1);
      start = 1'b1; cyc(2); start = 1'b0;
      chk(!busy && !soc, "R7 start ignored when halted idle", {busy, soc}, 0);
      susp = 1'b0;
      cyc(1);
      chk(halted == 1'b0, "R12 release", halted, 0);
      seq_len = 4'd2;
      auto_done = 1'b1;
      r0 = rises;
      start = 1'b1;
      wait_busy(1'b1, 10, "R9 start");
      start = 1'b0;
      susp = 1'b1;
      wait_busy(1'b0, 500, "R9 sequence ends");
      cyc(1);
      chk(halted == 1'b1, "R9 halted after sequence", halted, 1);
      chk(rises - r0 == 3, "R9 full sequence", rises - r0, 3);
      start = 1'b1; cyc(2); start = 1'b0;
      chk(!busy && !soc, "R7/R9 start ignored", {busy, soc}, 0);
      susp = 1'b0;
      cyc(1);
      chk(halted == 1'b0 && !busy, "R9 release to idle", {halted, busy}, 0);
      auto_done = 1'b0;

      // R10: halt at conversion end
      reg_write(16'h2100);
      auto_done = 1'b1;
      r0 = rises;
      start = 1'b1;
      wait_busy(1'b1, 10, "R10 start");
      start = 1'b0;
      susp = 1'b1;
      for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
      chk(halted && busy, "R10 halted mid sequence", {halted, busy}, 3);
      chk(rises - r0 == 1, "R10 one conversion before halt", rises - r0, 1);
      cyc(5);
      chk(!soc && halted, "R10 stays halted", {soc, halted}, 1);
      susp = 1'b0;
      wait_busy(1'b0, 500, "R10 resume");
      cyc(2);
      chk(rises - r0 == 3, "R10 count kept", rises - r0, 3);
      auto_done = 1'b0;

      // R11: immediate halt, restart of soc
      reg_write(16'h3300);
      seq_len = 4'd0;
      start = 1'b1;
      wait_busy(1'b1, 10, "R11 start");
      start = 1'b0;
      cyc(1);
      susp = 1'b1;
      cyc(1);
      chk(halted && !soc && busy, "R11 halt in soc", {halted, soc, busy}, 5);
      cyc(3);
      h0 = soc_hi; r0 = rises;
      susp = 1'b0;
      cyc(8);
      chk(soc_hi - h0 == 4, "R11 full soc after resume", soc_hi - h0, 4);
      chk(busy == 1'b1, "R11 waits for done", busy, 1);
      susp = 1'b1;
      cyc(1);
      chk(halted == 1'b1, "R11 halt in wait", halted, 1);
      man_done = 1'b1; cyc(2); man_done = 1'b0;
      susp = 1'b0;
      cyc(6);
      chk(rises - r0 == 2 && busy, "R11 done during halt ignored", rises - r0, 2);
      man_done = 1'b1; cyc(2); man_done = 1'b0;
      chk(busy == 1'b0, "R11 done ends sequence", busy, 0);

      finish_run();
   end
endmodule